// File: doc/BRIEF.md
# Raster Timing Generator with Border and Display Window

This block produces the horizontal and vertical timing for one video output. A horizontal counter runs across each line and a vertical counter runs across each field. From the counter values and a set of programmed positions it derives horizontal and vertical sync pulses, a visible region that is framed by a border, and a display window nested inside that region. It also produces the pixel column and line row of the current position inside the window. Software programs the line and field lengths, the border box, the window origin and size, and the mode bits through a simple 32-bit register write port.

Every register write lands in a staging copy. The staging copy moves into the live copy only at a frame boundary, which is the cycle where both counters wrap, or on every cycle while the generator is idle. As a result, a frame that has started never changes its timing. Blanking does not touch the sync pulses. Instead, it makes the border cover the whole visible region. Interlaced scanning alternates two fields, and each field has its own vertical window origin. Line doubling halves the reported row, and pixel doubling halves the reported column.

A three-state sequencer controls the counters:

- ST_OFF: the generator is idle, the counters are held at zero and all outputs are low.
- ST_FIELD0: the generator is scanning the first (or only) field.
- ST_FIELD1: the generator is scanning the second interlaced field.

The transitions are:

- ST_OFF to ST_FIELD0 when the staged video enable is set.
- ST_FIELD0 to ST_FIELD1 at a frame boundary when the staged interlace bit is set.
- ST_FIELD0 to ST_FIELD0 at a frame boundary when the staged interlace bit is clear.
- ST_FIELD1 to ST_FIELD0 at a frame boundary.
- ST_FIELD0 or ST_FIELD1 to ST_OFF at a frame boundary when the staged video enable is clear.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset all registers are zero, the generator is idle, and hsync, vsync, border_active, window_active, pix_x, line_y, field and clk_double are all 0.
- R2: The length register (address 0) holds the last horizontal count in bits 15:0 and the last line count in bits 31:16. The horizontal count runs 0..h_last and then returns to 0, so a line is h_last+1 clocks. Hsync is high while the horizontal count is below the horizontal border start.
- R3: The vertical count runs 0..v_last and advances once per line. Vsync is high while the vertical count is below the vertical border start.
- R4: The horizontal border register (address 1) and the vertical border register (address 2) each hold the start in bits 31:16 and the stop in bits 15:0. A position is visible when the start is at or below the count and the count is below the stop, on both axes. border_active is high for visible positions where window_active is low.
- R5: The window origin is given by address 3 bits 15:0 (horizontal) and by address 4 (vertical), where bits 15:0 apply to field 0 and bits 31:16 apply to field 1. The window size is given by address 5, with the width in bits 15:0 and the height in bits 31:16. window_active is high only when the position is visible and lies within [origin, origin+size) on both axes.
- R6: Bit 3 of address 6 (blank), or a clear bit 0 of address 8 (display enable), holds window_active low. In that case border_active covers the whole visible region while sync is unchanged.
- R7: While window_active is high, pix_x is the horizontal offset from the origin and line_y is the vertical offset from the origin. Each offset is shifted right by one when doubling is on: bit 0 of address 6 for pix_x, and bit 1 of address 8 for line_y. Both are 0 when window_active is low.
- R8: Bit 4 of address 7 selects interlace. When it is set, the field output alternates 0,1,0,... on successive fields, and the field-1 vertical origin is used in field 1. When it is clear, field stays 0.
- R9: Register writes take effect only at the cycle where both counters wrap, or on the next cycle while idle. Bit 8 of address 7 enables video. When it is cleared, the generator finishes the current frame and then goes idle. Writes to addresses 9..15 are ignored.
- R10: The clk_double output reflects bit 23 of address 8, subject to the same deferred update as R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |
| border_active | output | 1 | Visible position outside the live window |
| window_active | output | 1 | Position inside the live display window |
| pix_x | output | 16 | Column inside the window |
| line_y | output | 16 | Row inside the window |
| field | output | 1 | Current interlace field |
| clk_double | output | 1 | Doubled pixel clock select |

## Verification
The bench writes the timing registers in the middle of a frame. A design that applied a write at once would shift sync or the window part-way through that frame, and the per-cycle comparison would catch the shift at the next position. Blanking and a cleared display enable are each run for whole frames, to catch a design that drops sync or leaves window pixels showing instead of widening the border. Interlaced frames are run with different field origins, to catch a field that fails to toggle or that reads the wrong origin copy. A window that extends past the border stop is also run, to catch a window that is not clipped to the visible region. Doubling of both coordinates is exercised, and so is shutdown through the video enable bit, where the generator must complete the frame and then go silent.

// File: rtl/raster_pkg.sv
package raster_pkg;
    parameter int CNT_W  = 16;
    parameter int REG_DW = 32;
    parameter int REG_AW = 4;
    localparam int HALF  = REG_DW / 2;

    localparam logic [REG_AW-1:0] A_LENGTH  = 4'd0;
    localparam logic [REG_AW-1:0] A_HBORDER = 4'd1;
    localparam logic [REG_AW-1:0] A_VBORDER = 4'd2;
    localparam logic [REG_AW-1:0] A_WIN_H0  = 4'd3;
    localparam logic [REG_AW-1:0] A_WIN_V0  = 4'd4;
    localparam logic [REG_AW-1:0] A_WIN_SZ  = 4'd5;
    localparam logic [REG_AW-1:0] A_WIN_CFG = 4'd6;
    localparam logic [REG_AW-1:0] A_SCAN    = 4'd7;
    localparam logic [REG_AW-1:0] A_OUTMODE = 4'd8;

    localparam int BIT_PIX_DBL  = 0;
    localparam int BIT_BLANK    = 3;
    localparam int BIT_ILACE    = 4;
    localparam int BIT_VID_EN   = 8;
    localparam int BIT_DISP_EN  = 0;
    localparam int BIT_LINE_DBL = 1;
    localparam int BIT_CLK_DBL  = 23;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_FIELD0 = 2'd1,
        ST_FIELD1 = 2'd2
    } scan_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] h_last;
        logic [CNT_W-1:0] v_last;
        logic [CNT_W-1:0] hb_start;
        logic [CNT_W-1:0] hb_stop;
        logic [CNT_W-1:0] vb_start;
        logic [CNT_W-1:0] vb_stop;
        logic [CNT_W-1:0] win_h0;
        logic [CNT_W-1:0] win_v0_f0;
        logic [CNT_W-1:0] win_v0_f1;
        logic [CNT_W-1:0] win_w;
        logic [CNT_W-1:0] win_h;
        logic             blank;
        logic             pix_dbl;
        logic             video_en;
        logic             interlace;
        logic             disp_en;
        logic             line_dbl;
        logic             clk_dbl;
    } raster_cfg_t;
endpackage

// File: rtl/raster_cfg_regs.sv
module raster_cfg_regs
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              load,
    output logic              stg_video_en,
    output logic              stg_interlace,
    output raster_cfg_t       live
);
    raster_cfg_t staged;

    // staging copy: written by software at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_LENGTH: begin
                    staged.h_last <= wr_data[0 +: CNT_W];
                    staged.v_last <= wr_data[HALF +: CNT_W];
                end
                A_HBORDER: begin
                    staged.hb_stop  <= wr_data[0 +: CNT_W];
                    staged.hb_start <= wr_data[HALF +: CNT_W];
                end
                A_VBORDER: begin
                    staged.vb_stop  <= wr_data[0 +: CNT_W];
                    staged.vb_start <= wr_data[HALF +: CNT_W];
                end
                A_WIN_H0: begin
                    staged.win_h0 <= wr_data[0 +: CNT_W];
                end
                A_WIN_V0: begin
                    staged.win_v0_f0 <= wr_data[0 +: CNT_W];
                    staged.win_v0_f1 <= wr_data[HALF +: CNT_W];
                end
                A_WIN_SZ: begin
                    staged.win_w <= wr_data[0 +: CNT_W];
                    staged.win_h <= wr_data[HALF +: CNT_W];
                end
                A_WIN_CFG: begin
                    staged.blank   <= wr_data[BIT_BLANK];
                    staged.pix_dbl <= wr_data[BIT_PIX_DBL];
                end
                A_SCAN: begin
                    staged.video_en  <= wr_data[BIT_VID_EN];
                    staged.interlace <= wr_data[BIT_ILACE];
                end
                A_OUTMODE: begin
                    staged.disp_en  <= wr_data[BIT_DISP_EN];
                    staged.line_dbl <= wr_data[BIT_LINE_DBL];
                    staged.clk_dbl  <= wr_data[BIT_CLK_DBL];
                end
                default: begin
                end
            endcase
        end
    end

    // live copy: follows staging only at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else if (load) begin
            live <= staged;
        end
    end

    assign stg_video_en  = staged.video_en;
    assign stg_interlace = staged.interlace;
endmodule

// File: rtl/raster_scan_seq.sv
module raster_scan_seq
    import raster_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] h_last,
    input  logic [CNT_W-1:0] v_last,
    input  logic             stg_video_en,
    input  logic             stg_interlace,
    output scan_state_e      state,
    output logic [CNT_W-1:0] hcnt,
    output logic [CNT_W-1:0] vcnt,
    output logic             load
);
    scan_state_e state_nxt;
    logic        line_end;
    logic        frame_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and strobes
    always_comb begin
        line_end  = (hcnt >= h_last);
        frame_end = (state != ST_OFF) && line_end && (vcnt >= v_last);
        load      = (state == ST_OFF) || frame_end;
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (stg_video_en) state_nxt = ST_FIELD0;
            end
            ST_FIELD0: begin
                if (frame_end) begin
                    if (!stg_video_en)      state_nxt = ST_OFF;
                    else if (stg_interlace) state_nxt = ST_FIELD1;
                    else                    state_nxt = ST_FIELD0;
                end
            end
            ST_FIELD1: begin
                if (frame_end) begin
                    if (!stg_video_en) state_nxt = ST_OFF;
                    else               state_nxt = ST_FIELD0;
                end
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // raster counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (load) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
            vcnt <= vcnt + CNT_W'(1);
        end else begin
            hcnt <= hcnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/raster_region.sv
module raster_region
    import raster_pkg::*;
(
    input  scan_state_e      state,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] vcnt,
    input  logic             video_en,
    input  logic [CNT_W-1:0] hb_start,
    input  logic [CNT_W-1:0] hb_stop,
    input  logic [CNT_W-1:0] vb_start,
    input  logic [CNT_W-1:0] vb_stop,
    input  logic [CNT_W-1:0] win_h0,
    input  logic [CNT_W-1:0] win_v0_f0,
    input  logic [CNT_W-1:0] win_v0_f1,
    input  logic [CNT_W-1:0] win_w,
    input  logic [CNT_W-1:0] win_h,
    input  logic             blank,
    input  logic             disp_en,
    input  logic             pix_dbl,
    input  logic             line_dbl,
    output logic             hsync,
    output logic             vsync,
    output logic             border_active,
    output logic             window_active,
    output logic [CNT_W-1:0] pix_x,
    output logic [CNT_W-1:0] line_y,
    output logic             field
);
    logic             run;
    logic [CNT_W-1:0] win_v0;
    logic [CNT_W:0]   h_win_end;
    logic [CNT_W:0]   v_win_end;
    logic             visible;
    logic             in_win;
    logic [CNT_W-1:0] dh;
    logic [CNT_W-1:0] dv;

    always_comb begin
        run       = (state != ST_OFF) && video_en;
        field     = (state == ST_FIELD1);
        win_v0    = field ? win_v0_f1 : win_v0_f0;
        h_win_end = {1'b0, win_h0} + {1'b0, win_w};
        v_win_end = {1'b0, win_v0} + {1'b0, win_h};

        hsync   = run && (hcnt < hb_start);
        vsync   = run && (vcnt < vb_start);
        visible = run && (hcnt >= hb_start) && (hcnt < hb_stop)
                      && (vcnt >= vb_start) && (vcnt < vb_stop);
        in_win  = (hcnt >= win_h0) && ({1'b0, hcnt} < h_win_end)
               && (vcnt >= win_v0) && ({1'b0, vcnt} < v_win_end);

        window_active = visible && in_win && !blank && disp_en;
        border_active = visible && !window_active;

        dh     = hcnt - win_h0;
        dv     = vcnt - win_v0;
        pix_x  = window_active ? (dh >> pix_dbl)  : '0;
        line_y = window_active ? (dv >> line_dbl) : '0;
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              border_active,
    output logic              window_active,
    output logic [CNT_W-1:0]  pix_x,
    output logic [CNT_W-1:0]  line_y,
    output logic              field,
    output logic              clk_double
);
    raster_cfg_t      cfg;
    scan_state_e      state;
    logic [CNT_W-1:0] hcnt;
    logic [CNT_W-1:0] vcnt;
    logic             load;
    logic             stg_video_en;
    logic             stg_interlace;

    raster_cfg_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (reg_wr_en),
        .wr_addr       (reg_addr),
        .wr_data       (reg_wdata),
        .load          (load),
        .stg_video_en  (stg_video_en),
        .stg_interlace (stg_interlace),
        .live          (cfg)
    );

    raster_scan_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .h_last        (cfg.h_last),
        .v_last        (cfg.v_last),
        .stg_video_en  (stg_video_en),
        .stg_interlace (stg_interlace),
        .state         (state),
        .hcnt          (hcnt),
        .vcnt          (vcnt),
        .load          (load)
    );

    raster_region u_region (
        .state         (state),
        .hcnt          (hcnt),
        .vcnt          (vcnt),
        .video_en      (cfg.video_en),
        .hb_start      (cfg.hb_start),
        .hb_stop       (cfg.hb_stop),
        .vb_start      (cfg.vb_start),
        .vb_stop       (cfg.vb_stop),
        .win_h0        (cfg.win_h0),
        .win_v0_f0     (cfg.win_v0_f0),
        .win_v0_f1     (cfg.win_v0_f1),
        .win_w         (cfg.win_w),
        .win_h         (cfg.win_h),
        .blank         (cfg.blank),
        .disp_en       (cfg.disp_en),
        .pix_dbl       (cfg.pix_dbl),
        .line_dbl      (cfg.line_dbl),
        .hsync         (hsync),
        .vsync         (vsync),
        .border_active (border_active),
        .window_active (window_active),
        .pix_x         (pix_x),
        .line_y        (line_y),
        .field         (field)
    );

    assign clk_double = cfg.clk_dbl;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
    import raster_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input scan_state_e      state,
    input logic             load,
    input logic [CNT_W-1:0] hcnt,
    input logic [CNT_W-1:0] h_last,
    input logic [CNT_W-1:0] hb_start,
    input logic             blank,
    input logic             disp_en,
    input logic             interlace,
    input raster_cfg_t      cfg,
    input logic             hsync,
    input logic             vsync,
    input logic             border_active,
    input logic             window_active,
    input logic [CNT_W-1:0] pix_x,
    input logic [CNT_W-1:0] line_y,
    input logic             field
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !(hsync || vsync || border_active || window_active));

    p_hsync_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && hcnt == '0 && hb_start != '0) |-> hsync);

    p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && !load && hcnt == h_last) |=> (hcnt == '0));

    p_regions_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        window_active |-> !border_active);

    p_blank_hides_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blank || !disp_en) |-> !window_active);

    p_coord_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !window_active |-> (pix_x == '0 && line_y == '0));

    p_field_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !interlace |-> !field);

    p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg));
endmodule

bind raster_timing_gen raster_timing_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .load          (load),
    .hcnt          (hcnt),
    .h_last        (cfg.h_last),
    .hb_start      (cfg.hb_start),
    .blank         (cfg.blank),
    .disp_en       (cfg.disp_en),
    .interlace     (cfg.interlace),
    .cfg           (cfg),
    .hsync         (hsync),
    .vsync         (vsync),
    .border_active (border_active),
    .window_active (window_active),
    .pix_x         (pix_x),
    .line_y        (line_y),
    .field         (field)
);

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        hsync, vsync, border_active, window_active, field, clk_double;
    logic [15:0] pix_x, line_y;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    raster_timing_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .hsync         (hsync),
        .vsync         (vsync),
        .border_active (border_active),
        .window_active (window_active),
        .pix_x         (pix_x),
        .line_y        (line_y),
        .field         (field),
        .clk_double    (clk_double)
    );

    // behavioural reference model
    logic [31:0] m_stg [9];
    logic [31:0] m_live [9];
    int m_st = 0;
    int m_hc = 0;
    int m_vc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 9; i++) begin
                m_stg[i]  = '0;
                m_live[i] = '0;
            end
            m_st = 0; m_hc = 0; m_vc = 0;
        end else begin
            int hl, vl, ns;
            bit fe, ld, en, il;
            hl = int'(m_live[0][15:0]);
            vl = int'(m_live[0][31:16]);
            en = m_stg[7][8];
            il = m_stg[7][4];
            fe = (m_st != 0) && (m_hc >= hl) && (m_vc >= vl);
            ld = (m_st == 0) || fe;
            ns = m_st;
            if (m_st == 0) ns = en ? 1 : 0;
            else if (fe) ns = !en ? 0 : ((m_st == 1 && il) ? 2 : 1);
            if (ld) begin
                m_hc = 0; m_vc = 0;
            end else if (m_hc >= hl) begin
                m_hc = 0; m_vc = m_vc + 1;
            end else begin
                m_hc = m_hc + 1;
            end
            m_st = ns;
            if (ld)
                for (int i = 0; i < 9; i++) m_live[i] = m_stg[i];
            if (reg_wr_en && reg_addr < 4'd9) m_stg[reg_addr] = reg_wdata;
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int hbs, hbe, vbs, vbe, wh0, wv0, ww, wh, e_px, e_ly;
            bit run, fld, vis, inw, e_win, e_bor;
            run = (m_st != 0);
            fld = (m_st == 2);
            hbs = int'(m_live[1][31:16]); hbe = int'(m_live[1][15:0]);
            vbs = int'(m_live[2][31:16]); vbe = int'(m_live[2][15:0]);
            wh0 = int'(m_live[3][15:0]);
            wv0 = fld ? int'(m_live[4][31:16]) : int'(m_live[4][15:0]);
            ww  = int'(m_live[5][15:0]);  wh = int'(m_live[5][31:16]);
            vis = run && m_hc >= hbs && m_hc < hbe && m_vc >= vbs && m_vc < vbe;
            inw = m_hc >= wh0 && m_hc < wh0 + ww && m_vc >= wv0 && m_vc < wv0 + wh;
            e_win = vis && inw && !m_live[6][3] && m_live[8][0];
            e_bor = vis && !e_win;
            e_px = e_win ? ((m_hc - wh0) >> m_live[6][0]) : 0;
            e_ly = e_win ? ((m_vc - wv0) >> m_live[8][1]) : 0;
            cmp("R2 hsync", int'(hsync), int'(run && m_hc < hbs));
            cmp("R3 vsync", int'(vsync), int'(run && m_vc < vbs));
            cmp("R4 R6 border_active", int'(border_active), int'(e_bor));
            cmp("R5 R6 R9 window_active", int'(window_active), int'(e_win));
            cmp("R7 pix_x", int'(pix_x), e_px);
            cmp("R7 R8 line_y", int'(line_y), e_ly);
            cmp("R8 field", int'(field), int'(fld));
            cmp("R10 clk_double", int'(clk_double), int'(m_live[8][23]));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cmp("R1 reset outputs", int'({hsync, vsync, border_active, window_active,
            field, clk_double}), 0);
        cmp("R1 reset coords", int'(pix_x) + int'(line_y), 0);
        idle(20);
        // progressive frame: 40 clocks x 25 lines
        wr(4'd0, {16'd24, 16'd39});
        wr(4'd1, {16'd4, 16'd36});
        wr(4'd2, {16'd2, 16'd22});
        wr(4'd3, 32'd8);
        wr(4'd4, {16'd5, 16'd4});
        wr(4'd5, {16'd12, 16'd20});
        wr(4'd8, 32'h1);
        wr(4'd7, 32'h100);
        idle(2100);
        // doubling, written mid-frame (R7, R9)
        idle(333);
        wr(4'd6, 32'h1);
        wr(4'd8, 32'h3);
        wr(4'd12, 32'hFFFF_FFFF);
        idle(2200);
        // blank (R6)
        wr(4'd6, 32'h8);
        idle(1500);
        // display disabled (R6)
        wr(4'd6, 32'h0);
        wr(4'd8, 32'h0);
        idle(1500);
        // interlace with distinct field origins (R8)
        wr(4'd8, 32'h1);
        wr(4'd4, {16'd9, 16'd3});
        wr(4'd7, 32'h110);
        idle(4200);
        // clock doubling, new totals mid-frame, window past border (R10, R9, R5)
        idle(177);
        wr(4'd8, 32'h0080_0001);
        wr(4'd0, {16'd19, 16'd29});
        wr(4'd1, {16'd3, 16'd25});
        wr(4'd3, 32'd14);
        wr(4'd5, {16'd30, 16'd40});
        wr(4'd7, 32'h100);
        idle(2000);
        // shutdown (R9)
        wr(4'd7, 32'h0);
        idle(1300);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule